// File: doc/BRIEF.md
# LCD Sync Timing Generator

This block produces the line and frame timing for a 320x240 TFT panel that is fed one byte per port clock. Every interval is counted in port clock ticks, and each pixel takes several ticks: two for 16-bit RGB565 data and three for 24-bit RGB888 data. The block drives an active-low horizontal sync, an active-low vertical sync and a data-enable strobe. Alongside them it gives the column of the current pixel, the active row, and the byte phase within the pixel, so that a pixel source can place its bytes.

Each line lasts 336 pixel times. The horizontal sync pulse is two pixel times wide and opens the line. Active data starts after a leading gap of seven pixel times. That gap is stretched by a fixed pipeline allowance of three ticks for RGB565 or five ticks for RGB888, which covers the external byte packer. A frame holds the 240 active lines and four blanking lines: two blanking lines come before the active rows and two come after. The vertical sync pulse opens one tick ahead of the horizontal sync of the first line of each frame.

An enable input starts and stops the generator. While it is low, all counters are held at rest and the pixel format is taken from the format input. While it is high, the format stays fixed.

Top module: `lcd_sync_gen`

## Requirements
- R1: Out of reset, and in every cycle that follows a clock edge at which `en_i` was low, `hs_no` and `vs_no` are 1, while `de_o`, `pix_o`, `line_o` and `phase_o` are 0.
- R2: The format code `fmt_i`=0 selects RGB565 with 2 ticks per pixel, and `fmt_i`=1 selects RGB888 with 3 ticks per pixel. A line lasts LINE_PIX (336) times the ticks per pixel.
- R3: `hs_no` is low for the first HS_PIX (2) pixel times of every line and high for the rest of the line.
- R4: The first tick with `de_o` high in a line comes START_PIX (7) pixel times after the line starts, plus 3 ticks for RGB565 or 5 ticks for RGB888.
- R5: A frame lasts ACT_LINES+BLANK_LINES (244) lines. `vs_no` is low for VS_PIX (2) pixel times once per frame.
- R6: `vs_no` falls exactly one tick before `hs_no` falls. This holds in the first cycle after the generator is enabled and at the start of every later frame.
- R7: On each active line, `de_o` is high for exactly ACT_PIX (320) times the ticks per pixel, in consecutive ticks. The active lines are lines BLANK_LINES/2 up to BLANK_LINES/2+ACT_LINES-1 of the frame, and `de_o` stays low on all other lines.
- R8: While `de_o` is high, `phase_o` counts 0 up to ticks-per-pixel minus 1 within each pixel, and `pix_o` counts pixels from 0 on each line. `line_o` gives the active row from 0. All three read 0 while `de_o` is low.
- R9: Changes on `fmt_i` while the generator is enabled have no effect on any output.
- R10: A format chosen while the generator is disabled takes effect from the next enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Port clock, one tick per byte |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low holds all counters at rest |
| fmt_i | input | 1 | Pixel format: 0 RGB565, 1 RGB888 |
| hs_no | output | 1 | Horizontal sync, active low |
| vs_no | output | 1 | Vertical sync, active low |
| de_o | output | 1 | Data enable, high for active pixel bytes |
| pix_o | output | $clog2(ACT_PIX) | Pixel column within the active line |
| line_o | output | $clog2(ACT_LINES) | Active row within the frame |
| phase_o | output | 2 | Byte phase within the current pixel |

## Verification
The bench uses shrunk line and frame dimensions so that it can cover several full frames in each format and compare every output against a tick-exact model in every cycle. The RGB565 runs and the RGB888 runs tell apart the per-format ticks-per-pixel and pipeline allowances, so a swapped or shared value shows up. One run wiggles the format input while enabled, which separates a format that is properly frozen from one that leaks through. Disabling in the middle of a frame and then re-enabling in the other format shows whether the rest state is clean and whether the new format is picked up, including the one-tick lead of vertical sync over horizontal sync.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    typedef enum logic {
        FMT_RGB565 = 1'b0,
        FMT_RGB888 = 1'b1
    } pix_fmt_e;

    function automatic int unsigned ticks_per_pix(pix_fmt_e f);
        return (f == FMT_RGB888) ? 32'd3 : 32'd2;
    endfunction

endpackage

// File: rtl/lcdt_timebase.sv
module lcdt_timebase
    import lcdt_pkg::*;
#(
    parameter int unsigned LINE_PIX    = 336,
    parameter int unsigned HS_PIX      = 2,
    parameter int unsigned VS_PIX      = 2,
    parameter int unsigned ACT_LINES   = 240,
    parameter int unsigned BLANK_LINES = 4,
    parameter int unsigned HW          = $clog2(LINE_PIX * 3),
    parameter int unsigned VW          = $clog2(ACT_LINES + BLANK_LINES)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  pix_fmt_e      fmt_i,
    output logic          run_o,
    output logic [HW-1:0] h_o,
    output logic [VW-1:0] v_o,
    output logic          hs_o,
    output logic          vs_o
);

    localparam int unsigned VTOT = ACT_LINES + BLANK_LINES;
    localparam int unsigned VCW  = $clog2(VS_PIX * 3 + 1);
    localparam logic [VW-1:0] V_LAST = VW'(VTOT - 1);

    typedef struct packed {
        logic           run;
        logic [HW-1:0]  h;
        logic [VW-1:0]  v;
        logic [VCW-1:0] vsc;
    } tb_state_t;

    tb_state_t st_d, st_q;

    int unsigned   tpp;
    logic [HW-1:0] htot_m1;
    logic [HW-1:0] hs_t;
    logic [VCW-1:0] vs_t;

    always_comb begin
        tpp     = ticks_per_pix(fmt_i);
        htot_m1 = HW'(LINE_PIX * tpp - 1);
        hs_t    = HW'(HS_PIX * tpp);
        vs_t    = VCW'(VS_PIX * tpp);
        st_d    = st_q;
        if (!en_i) begin
            st_d = '0;
        end else if (!st_q.run) begin
            // start one tick before line 0 so vertical sync leads
            st_d.run = 1'b1;
            st_d.h   = htot_m1;
            st_d.v   = V_LAST;
            st_d.vsc = vs_t;
        end else begin
            if (st_q.h == htot_m1) begin
                st_d.h = '0;
                st_d.v = (st_q.v == V_LAST) ? '0 : st_q.v + 1'b1;
            end else begin
                st_d.h = st_q.h + 1'b1;
            end
            if ((st_q.h == htot_m1 - 1'b1) && (st_q.v == V_LAST)) begin
                st_d.vsc = vs_t;
            end else if (st_q.vsc != '0) begin
                st_d.vsc = st_q.vsc - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o = st_q.run;
    assign h_o   = st_q.h;
    assign v_o   = st_q.v;
    assign hs_o  = st_q.run && (st_q.h < hs_t);
    assign vs_o  = st_q.run && (st_q.vsc != '0);

    AST_H_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_o |-> (h_o <= htot_m1)); // R2

    AST_VS_AT_SEAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vs_o |-> ((v_o == V_LAST) || (v_o == '0))); // R5

endmodule

// File: rtl/lcdt_window.sv
module lcdt_window
    import lcdt_pkg::*;
#(
    parameter int unsigned ACT_PIX     = 320,
    parameter int unsigned ACT_LINES   = 240,
    parameter int unsigned BLANK_LINES = 4,
    parameter int unsigned START_PIX   = 7,
    parameter int unsigned DLY_565     = 3,
    parameter int unsigned DLY_888     = 5,
    parameter int unsigned HW          = 10,
    parameter int unsigned VW          = 8,
    parameter int unsigned PXW         = $clog2(ACT_PIX),
    parameter int unsigned LNW         = $clog2(ACT_LINES)
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           run_i,
    input  logic [HW-1:0]  h_i,
    input  logic [VW-1:0]  v_i,
    input  pix_fmt_e       fmt_i,
    output logic           de_o,
    output logic [PXW-1:0] pix_o,
    output logic [LNW-1:0] line_o,
    output logic [1:0]     phase_o
);

    localparam logic [VW-1:0] TOP_V = VW'(BLANK_LINES / 2);
    localparam logic [VW-1:0] BOT_V = VW'(BLANK_LINES / 2 + ACT_LINES);

    typedef struct packed {
        logic [1:0]     sub;
        logic [PXW-1:0] px;
    } win_state_t;

    win_state_t ws_d, ws_q;

    int unsigned   tpp;
    logic [HW-1:0] st_h;
    logic [HW-1:0] end_h;
    logic [1:0]    sub_last;
    logic          hwin;
    logic          vwin;

    always_comb begin
        tpp      = ticks_per_pix(fmt_i);
        st_h     = HW'(START_PIX * tpp + ((fmt_i == FMT_RGB888) ? DLY_888 : DLY_565));
        end_h    = HW'(START_PIX * tpp + ((fmt_i == FMT_RGB888) ? DLY_888 : DLY_565)
                       + ACT_PIX * tpp);
        sub_last = 2'(tpp - 1);
        hwin     = (h_i >= st_h) && (h_i < end_h);
        vwin     = (v_i >= TOP_V) && (v_i < BOT_V);
        ws_d     = ws_q;
        if (!run_i || (h_i == st_h - 1'b1)) begin
            ws_d = '0;
        end else if (hwin && (h_i != end_h - 1'b1)) begin
            if (ws_q.sub == sub_last) begin
                ws_d.sub = '0;
                ws_d.px  = ws_q.px + 1'b1;
            end else begin
                ws_d.sub = ws_q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ws_q <= '0;
        end else begin
            ws_q <= ws_d;
        end
    end

    assign de_o    = run_i && hwin && vwin;
    assign pix_o   = de_o ? ws_q.px : '0;
    assign phase_o = de_o ? ws_q.sub : '0;
    assign line_o  = de_o ? LNW'(v_i - TOP_V) : '0;

    AST_PHASE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        de_o |-> (phase_o <= sub_last)); // R8

    AST_PIX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (de_o && $past(de_o) && (phase_o == 2'd0)) |-> (pix_o == $past(pix_o) + 1'b1)); // R8

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
    import lcdt_pkg::*;
#(
    parameter int unsigned ACT_PIX     = 320,
    parameter int unsigned ACT_LINES   = 240,
    parameter int unsigned LINE_PIX    = 336,
    parameter int unsigned HS_PIX      = 2,
    parameter int unsigned VS_PIX      = 2,
    parameter int unsigned START_PIX   = 7,
    parameter int unsigned BLANK_LINES = 4,
    parameter int unsigned DLY_565     = 3,
    parameter int unsigned DLY_888     = 5,
    localparam int unsigned PXW        = $clog2(ACT_PIX),
    localparam int unsigned LNW        = $clog2(ACT_LINES)
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           en_i,
    input  logic           fmt_i,
    output logic           hs_no,
    output logic           vs_no,
    output logic           de_o,
    output logic [PXW-1:0] pix_o,
    output logic [LNW-1:0] line_o,
    output logic [1:0]     phase_o
);

    localparam int unsigned HW = $clog2(LINE_PIX * 3);
    localparam int unsigned VW = $clog2(ACT_LINES + BLANK_LINES);

    typedef struct packed {
        pix_fmt_e fmt;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!en_i) begin
            cfg_d.fmt = pix_fmt_e'(fmt_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '{fmt: FMT_RGB565};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    logic          run;
    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;
    logic          hs_act;
    logic          vs_act;

    lcdt_timebase #(
        .LINE_PIX    (LINE_PIX),
        .HS_PIX      (HS_PIX),
        .VS_PIX      (VS_PIX),
        .ACT_LINES   (ACT_LINES),
        .BLANK_LINES (BLANK_LINES),
        .HW          (HW),
        .VW          (VW)
    ) u_timebase (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .fmt_i  (cfg_q.fmt),
        .run_o  (run),
        .h_o    (h_cnt),
        .v_o    (v_cnt),
        .hs_o   (hs_act),
        .vs_o   (vs_act)
    );

    lcdt_window #(
        .ACT_PIX     (ACT_PIX),
        .ACT_LINES   (ACT_LINES),
        .BLANK_LINES (BLANK_LINES),
        .START_PIX   (START_PIX),
        .DLY_565     (DLY_565),
        .DLY_888     (DLY_888),
        .HW          (HW),
        .VW          (VW),
        .PXW         (PXW),
        .LNW         (LNW)
    ) u_window (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run),
        .h_i     (h_cnt),
        .v_i     (v_cnt),
        .fmt_i   (cfg_q.fmt),
        .de_o    (de_o),
        .pix_o   (pix_o),
        .line_o  (line_o),
        .phase_o (phase_o)
    );

    assign hs_no = !hs_act;
    assign vs_no = !vs_act;

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (hs_no && vs_no && !de_o)); // R1

    AST_FMT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |=> $stable(cfg_q.fmt)); // R9

    AST_VS_LEADS_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(vs_no) && en_i) |=> $fell(hs_no)); // R6

    AST_NO_DE_IN_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hs_no |-> !de_o); // R4

endmodule

// File: tb/lcd_sync_gen_bench.sv
`timescale 1ns/1ps
module lcd_sync_gen_bench;

    localparam int AP  = 4;
    localparam int AL  = 3;
    localparam int LP  = 12;
    localparam int HSP = 2;
    localparam int VSP = 2;
    localparam int STP = 3;
    localparam int BL  = 4;
    localparam int VT  = AL + BL;
    localparam int TOPL = BL / 2;
    localparam int PXW = $clog2(AP);
    localparam int LNW = $clog2(AL);

    typedef struct {
        logic  hs_n;
        logic  vs_n;
        logic  de;
        int    pix;
        int    line;
        int    phase;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic fmt = 1'b0;
    logic           hs_n, vs_n, de;
    logic [PXW-1:0] pix;
    logic [LNW-1:0] line;
    logic [1:0]     phase;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;

    lcd_sync_gen #(
        .ACT_PIX (AP), .ACT_LINES (AL), .LINE_PIX (LP), .HS_PIX (HSP),
        .VS_PIX (VSP), .START_PIX (STP), .BLANK_LINES (BL),
        .DLY_565 (3), .DLY_888 (5)
    ) u_lcd_sync_gen (
        .clk_i (clk), .rst_ni (rst_n), .en_i (en), .fmt_i (fmt),
        .hs_no (hs_n), .vs_no (vs_n), .de_o (de),
        .pix_o (pix), .line_o (line), .phase_o (phase)
    );

    function automatic exp_t idle_item(string tag);
        exp_t e;
        e.hs_n = 1'b1; e.vs_n = 1'b1; e.de = 1'b0;
        e.pix = 0; e.line = 0; e.phase = 0; e.tag = tag;
        return e;
    endfunction

    // k = cycles since the enable was sampled high
    function automatic exp_t run_item(int k, int f, string base);
        exp_t e;
        int tpp, htot, frame, h, v, g, st;
        tpp   = f ? 3 : 2;
        htot  = LP * tpp;
        frame = htot * VT;
        if (k == 0) begin
            h = htot - 1; v = VT - 1;
        end else begin
            g = k - 1; h = g % htot; v = (g / htot) % VT;
        end
        st     = STP * tpp + (f ? 5 : 3);
        e.hs_n = !(h < HSP * tpp);
        e.vs_n = !((k % frame) < VSP * tpp);
        e.de   = (v >= TOPL) && (v < TOPL + AL) && (h >= st) && (h < st + AP * tpp);
        e.pix   = e.de ? (h - st) / tpp : 0;
        e.phase = e.de ? (h - st) % tpp : 0;
        e.line  = e.de ? v - TOPL : 0;
        if (base != "")        e.tag = base;
        else if (k <= 1)       e.tag = "R6";
        else if (e.de && h == st) e.tag = "R4";
        else if (h == 0)       e.tag = "R2";
        else                   e.tag = "";
        return e;
    endfunction

    task automatic cmp(string tag, string dflt, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d at %0t",
                     (tag != "") ? tag : dflt, what, act, exp, $time);
        end
    endtask

    // monitor: pops one expected item per cycle, compares away from the edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                cmp(e.tag, "R3", "hs_n",  int'(hs_n),  int'(e.hs_n));
                cmp(e.tag, "R5", "vs_n",  int'(vs_n),  int'(e.vs_n));
                cmp(e.tag, "R7", "de",    int'(de),    int'(e.de));
                cmp(e.tag, "R8", "pix",   int'(pix),   e.pix);
                cmp(e.tag, "R8", "line",  int'(line),  e.line);
                cmp(e.tag, "R8", "phase", int'(phase), e.phase);
            end
        end
    end

    task automatic idle_phase(int n, logic f, string tag);
        @(negedge clk);
        en  = 1'b0;
        fmt = f;
        #1;
        for (int i = 0; i < n; i++) sb.push_back(idle_item(tag));
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic run_phase(int n, int f, string base, bit wiggle);
        @(negedge clk);
        en = 1'b1;
        #1;
        for (int k = 0; k < n; k++) sb.push_back(run_item(k, f, base));
        for (int k = 0; k < n - 1; k++) begin
            @(negedge clk);
            if (wiggle && (k % 7 == 3)) fmt = ~fmt;
        end
    endtask

    initial begin
        #1;
        for (int i = 0; i < 3; i++) sb.push_back(idle_item("R1"));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle_phase(4, 1'b0, "R1");
        // RGB565: two full frames and a bit more
        run_phase(2 * LP * 2 * VT + 30, 0, "", 1'b0);
        // disable mid-frame, switch to RGB888
        idle_phase(5, 1'b1, "R1");
        run_phase(2 * LP * 3 * VT + 10, 1, "", 1'b0);
        // format wiggled while running must not matter
        idle_phase(4, 1'b0, "R1");
        run_phase(LP * 2 * VT + 50, 0, "R9", 1'b1);
        // new format chosen while idle takes effect at re-enable
        idle_phase(3, 1'b1, "R1");
        run_phase(LP * 3 * VT + 20, 1, "R10", 1'b0);
        idle_phase(4, 1'b0, "R1");
        wait (sb.size() == 0);
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule